// File: doc/BRIEF.md
# Vector Bitwise Test Flag Unit

This block turns two wide vector operands into a pair of condition flags. One flag reports whether the two operands have no set bit in common. The other reports whether every set bit of the first operand is also set in the second. An execution pipeline feeds it both operands with a strobe. It also supplies a width select, which chooses between the low 128 bits and the full 256 bits, and a mode select. The mode picks which bits take part: every bit, only the sign bit of each 32-bit element, or only the sign bit of each 64-bit element. The block returns a six-bit flag word in which only the zero and carry positions can ever be set.

Internally a mask generator selects the participating bits. Two fold-and-reduce units then test `E & G` and `E & ~G` for all-zero. In the wide setting each fold ORs the upper 128-bit half onto the lower half before the zero test. An optional output stage registers the flags. The stage is a two-state machine. In `OS_EMPTY` no result is presented. In `OS_LOADED` a result captured on the previous cycle is presented. Transition *capture* moves `OS_EMPTY` to `OS_LOADED` when the strobe is high. Transition *refill* keeps `OS_LOADED` in place when the strobe is high. Transition *drain* moves `OS_LOADED` to `OS_EMPTY` when the strobe is low. Transition *wait* keeps `OS_EMPTY` in place when the strobe is low.

Top module: `vtf_flag_unit`

## Requirements
- R1: The Z flag (bit 3 of the flag word) is 1 exactly when `opnd_e & opnd_g` is zero over every participating bit.
- R2: The C flag (bit 1 of the flag word) is 1 exactly when `opnd_e & ~opnd_g` is zero over every participating bit.
- R3: With `mode` = 0 every bit inside the active width participates. The reserved code `mode` = 3 behaves the same way.
- R4: With `mode` = 1 only bit 31 of each 32-bit element (bits 31, 63, 95, ...) participates.
- R5: With `mode` = 2 only bit 63 of each 64-bit element (bits 63, 127, 191, 255) participates.
- R6: With `wide` = 0 bits 255:128 of both operands have no effect on the flags. With `wide` = 1 the upper half participates on equal terms with the lower half.
- R7: The flag word is {O,S,Z,A,C,P} on bits [5:0]. Bits 5, 4, 2 and 0 are always 0.
- R8: With the output register enabled (the default), `flags_out` and `out_valid` present the result of an input one clock after `in_valid` is sampled high. `out_valid` is low on the clock after `in_valid` is sampled low.
- R9: While `in_valid` is low, `flags_out` holds its last value whatever the operands, width and mode do.
- R10: During reset `flags_out` is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands, width and mode are valid this cycle |
| wide | input | 1 | 1 = test 256 bits, 0 = test the low 128 bits |
| mode | input | 2 | 0 all bits, 1 dword sign bits, 2 qword sign bits, 3 same as 0 |
| opnd_e | input | 256 | First operand |
| opnd_g | input | 256 | Second operand |
| flags_out | output | 6 | Flag word {O,S,Z,A,C,P} |
| out_valid | output | 1 | `flags_out` carries a fresh result |

## Verification
The concurrent properties assume that `in_valid`, `wide`, `mode` and both operands are known, non-X values at every rising edge once reset is released. They also assume that a result is wanted every cycle the strobe is high, with no back-pressure. The stimulus meets both assumptions. It sets every input to a defined value at time zero, and it changes inputs only on falling edges. The Z and C properties use only the raw, unmasked operands. They therefore rely on masking being able only to remove bits from the test. The scoreboard's own reference checks the exact masked result.

// File: rtl/vtf_pkg.sv
package vtf_pkg;

    // Test granularity selector; the reserved code behaves as MODE_ALL.
    typedef enum logic [1:0] {
        MODE_ALL = 2'd0,
        MODE_DW  = 2'd1,
        MODE_QW  = 2'd2,
        MODE_RSV = 2'd3
    } vtf_mode_e;

    // Output stage occupancy.
    typedef enum logic {
        OS_EMPTY  = 1'b0,
        OS_LOADED = 1'b1
    } vtf_ostate_e;

    localparam int FLAG_W = 6;
    localparam int FLG_O  = 5;
    localparam int FLG_S  = 4;
    localparam int FLG_Z  = 3;
    localparam int FLG_A  = 2;
    localparam int FLG_C  = 1;
    localparam int FLG_P  = 0;

    localparam int DW_BITS = 32;
    localparam int QW_BITS = 64;

endpackage

// File: rtl/vtf_mask.sv
module vtf_mask
    import vtf_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  vtf_mode_e          mode,
    input  logic               wide,
    output logic [VEC_W-1:0]   mask
);

    localparam int HALF      = VEC_W / 2;
    localparam int N_DW_WIDE = VEC_W / DW_BITS;
    localparam int N_DW_NARR = HALF / DW_BITS;
    localparam int N_QW_WIDE = VEC_W / QW_BITS;
    localparam int N_QW_NARR = HALF / QW_BITS;

    for (genvar i = 0; i < VEC_W; i++) begin : g_bit
        localparam bit IS_DW_SIGN = ((i % DW_BITS) == DW_BITS - 1);
        localparam bit IS_QW_SIGN = ((i % QW_BITS) == QW_BITS - 1);
        localparam bit IS_UPPER   = (i >= HALF);
        logic pick;

        always_comb begin
            unique case (mode)
                MODE_DW: pick = IS_DW_SIGN;
                MODE_QW: pick = IS_QW_SIGN;
                default: pick = 1'b1;
            endcase
        end

        assign mask[i] = pick & (wide | ~IS_UPPER);
    end

    // Sign-only modes must select exactly one bit per element in range.
    always_comb begin
        if (mode == MODE_DW) begin
            p_dw_count_r4: assert ($countones(mask) == (wide ? N_DW_WIDE : N_DW_NARR))
                else $error("dword sign mask has wrong population");
        end
        if (mode == MODE_QW) begin
            p_qw_count_r5: assert ($countones(mask) == (wide ? N_QW_WIDE : N_QW_NARR))
                else $error("qword sign mask has wrong population");
        end
    end

endmodule

// File: rtl/vtf_fold_zero.sv
module vtf_fold_zero #(
    parameter int VEC_W = 256
) (
    input  logic [VEC_W-1:0] vec,
    input  logic             wide,
    output logic             all_zero
);

    localparam int HALF = VEC_W / 2;

    logic [HALF-1:0] upper_gated;
    logic [HALF-1:0] folded;

    assign upper_gated = wide ? vec[VEC_W-1:HALF] : '0;
    assign folded      = vec[HALF-1:0] | upper_gated;
    assign all_zero    = ~|folded;

endmodule

// File: rtl/vtf_flag_unit.sv
module vtf_flag_unit
    import vtf_pkg::*;
#(
    parameter int VEC_W   = 256,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              wide,
    input  logic [1:0]        mode,
    input  logic [VEC_W-1:0]  opnd_e,
    input  logic [VEC_W-1:0]  opnd_g,
    output logic [FLAG_W-1:0] flags_out,
    output logic              out_valid
);

    vtf_mode_e         mode_sel;
    logic [VEC_W-1:0]  sel_mask;
    logic [VEC_W-1:0]  both_v;
    logic [VEC_W-1:0]  eonly_v;
    logic              z_hit;
    logic              c_hit;
    logic [FLAG_W-1:0] flags_comb;

    assign mode_sel = vtf_mode_e'(mode);

    vtf_mask #(.VEC_W(VEC_W)) u_mask (
        .mode (mode_sel),
        .wide (wide),
        .mask (sel_mask)
    );

    assign both_v  = opnd_e &  opnd_g & sel_mask;
    assign eonly_v = opnd_e & ~opnd_g & sel_mask;

    vtf_fold_zero #(.VEC_W(VEC_W)) u_fold_z (
        .vec      (both_v),
        .wide     (wide),
        .all_zero (z_hit)
    );

    vtf_fold_zero #(.VEC_W(VEC_W)) u_fold_c (
        .vec      (eonly_v),
        .wide     (wide),
        .all_zero (c_hit)
    );

    always_comb begin
        flags_comb        = '0;
        flags_comb[FLG_Z] = z_hit;
        flags_comb[FLG_C] = c_hit;
    end

    if (REG_OUT) begin : g_reg
        vtf_ostate_e       state_q;
        vtf_ostate_e       state_d;
        logic [FLAG_W-1:0] flags_q;

        always_ff @(posedge clk) begin
            if (!rst_n) state_q <= OS_EMPTY;
            else        state_q <= state_d;
        end

        always_comb begin
            unique case (state_q)
                OS_EMPTY:  state_d = in_valid ? OS_LOADED : OS_EMPTY;
                OS_LOADED: state_d = in_valid ? OS_LOADED : OS_EMPTY;
                default:   state_d = OS_EMPTY;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n)        flags_q <= '0;
            else if (in_valid) flags_q <= flags_comb;
        end

        assign flags_out = flags_q;
        assign out_valid = (state_q == OS_LOADED);

        p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid)
            else $error("out_valid missing after accepted input");

        p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid)
            else $error("out_valid raised without input");

        p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(flags_out))
            else $error("flags changed while idle");

        p_z_disjoint_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && ((opnd_e & opnd_g) == '0)) |=> flags_out[FLG_Z])
            else $error("Z clear for disjoint operands");

        p_c_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && ((opnd_e & ~opnd_g) == '0)) |=> flags_out[FLG_C])
            else $error("C clear for contained operand");
    end else begin : g_comb
        assign flags_out = flags_comb;
        assign out_valid = in_valid;
    end

endmodule

// File: tb/vtf_flag_unit_test.sv
module vtf_flag_unit_test;

    logic         clk;
    logic         rst_n;
    logic         in_valid;
    logic         wide;
    logic [1:0]   mode;
    logic [255:0] opnd_e;
    logic [255:0] opnd_g;
    logic [5:0]   flags_out;
    logic         out_valid;

    int n_cmp;
    int n_bad;
    int n_push;
    int n_pop;

    typedef struct {
        logic [5:0] f;
        string      tag;
    } exp_t;

    exp_t sb[$];
    logic [5:0] last_exp;

    vtf_flag_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .wide      (wide),
        .mode      (mode),
        .opnd_e    (opnd_e),
        .opnd_g    (opnd_g),
        .flags_out (flags_out),
        .out_valid (out_valid)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Reference from the requirements: R1..R7.
    function automatic logic [5:0] ref_flags(input logic [255:0] e, input logic [255:0] g,
                                             input logic w, input logic [1:0] m);
        logic any_and;
        logic any_andn;
        any_and  = 1'b0;
        any_andn = 1'b0;
        for (int i = 0; i < 256; i++) begin
            logic part;
            if (!w && i >= 128)  part = 1'b0;
            else if (m == 2'd1)  part = ((i % 32) == 31);
            else if (m == 2'd2)  part = ((i % 64) == 63);
            else                 part = 1'b1;
            if (part && e[i] && g[i])  any_and  = 1'b1;
            if (part && e[i] && !g[i]) any_andn = 1'b1;
        end
        return {1'b0, 1'b0, !any_and, 1'b0, !any_andn, 1'b0};
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input logic ok, input string req, input logic [5:0] act, input logic [5:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [255:0] e, input logic [255:0] g,
                         input logic w, input logic [1:0] m, input string tag);
        exp_t item;
        @(negedge clk);
        opnd_e   = e;
        opnd_g   = g;
        wide     = w;
        mode     = m;
        in_valid = 1'b1;
        item.f   = ref_flags(e, g, w, m);
        item.tag = tag;
        last_exp = item.f;
        sb.push_back(item);
        n_push++;
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: one result expected per accepted input, in order (R8).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected out_valid", flags_out, 6'b0);
            end else begin
                exp_t item;
                item = sb.pop_front();
                n_pop++;
                check(flags_out == item.f, item.tag, flags_out, item.f);
            end
        end
    end

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL R8 watchdog expired actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [255:0] one1;
        n_cmp = 0; n_bad = 0; n_push = 0; n_pop = 0;
        rst_n = 1'b0; in_valid = 1'b0; wide = 1'b0; mode = 2'd0;
        opnd_e = '0; opnd_g = '0; last_exp = '0;
        repeat (3) @(negedge clk);
        check(flags_out == 6'b0, "R10 reset flags", flags_out, 6'b0);
        check({5'b0, out_valid} == 6'b0, "R10 reset valid", {5'b0, out_valid}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Whole-vector patterns (R1 R2 R3 R7)
        drive('0, '0, 1'b1, 2'd0, "R1 R2 all-zero");
        drive('1, '1, 1'b1, 2'd0, "R1 R7 all-one equal");
        drive('1, '0, 1'b1, 2'd0, "R2 all-one vs zero");
        drive('0, '1, 1'b0, 2'd0, "R2 zero E");
        drive('1, '1, 1'b1, 2'd3, "R3 reserved mode all-one");
        one1 = '0; one1[5] = 1'b1;
        drive(one1, one1, 1'b0, 2'd3, "R3 reserved single bit");
        drive(one1, one1, 1'b0, 2'd1, "R4 non-sign bit ignored");

        // Dword sign mode (R4)
        one1 = '0; one1[31] = 1'b1;
        drive(one1, one1, 1'b0, 2'd1, "R4 bit31 shared");
        drive(one1, '0, 1'b0, 2'd1, "R4 bit31 only in E");
        one1 = '0; one1[30] = 1'b1;
        drive(one1, '0, 1'b0, 2'd1, "R4 bit30 ignored");
        one1 = '0; one1[95] = 1'b1;
        drive(one1, one1, 1'b0, 2'd1, "R4 bit95 shared");

        // Qword sign mode (R5)
        one1 = '0; one1[63] = 1'b1;
        drive(one1, one1, 1'b0, 2'd2, "R5 bit63 shared");
        one1 = '0; one1[31] = 1'b1;
        drive(one1, one1, 1'b0, 2'd2, "R5 bit31 ignored");
        one1 = '0; one1[255] = 1'b1;
        drive(one1, '0, 1'b1, 2'd2, "R5 bit255 wide");

        // Width (R6)
        one1 = '0; one1[200] = 1'b1;
        drive(one1, one1, 1'b0, 2'd0, "R6 narrow ignores upper");
        drive(one1, one1, 1'b1, 2'd0, "R6 wide sees upper");
        drive(one1, '0, 1'b1, 2'd0, "R6 wide upper E only");
        one1 = '0; one1[223] = 1'b1;
        drive(one1, one1, 1'b0, 2'd1, "R6 narrow dword sign upper");
        drive(one1, one1, 1'b1, 2'd1, "R6 wide dword sign upper");

        // R9: idle with changed operands keeps flags
        go_idle();
        opnd_e = '1; opnd_g = '0; wide = 1'b1; mode = 2'd0;
        @(negedge clk);
        @(negedge clk);
        check(flags_out == last_exp, "R9 hold while idle", flags_out, last_exp);
        check({5'b0, out_valid} == 6'b0, "R8 valid low after idle", {5'b0, out_valid}, 6'b0);

        // Random, all modes and widths (R1..R6)
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int n = 0; n < 30; n++) begin
                    logic [255:0] a;
                    logic [255:0] b;
                    a = rnd256();
                    b = rnd256();
                    unique case (n % 3)
                        0: drive(a, b, w[0], m[1:0], "R1 R2 random");
                        1: drive(a & rnd256() & rnd256(), a | b, w[0], m[1:0], "R2 random subset");
                        default: drive(a & ~b, b, w[0], m[1:0], "R1 random disjoint");
                    endcase
                    if (n % 7 == 6) go_idle();
                end
            end
        end

        go_idle();
        repeat (3) @(negedge clk);
        check(n_pop == n_push, "R8 all results returned", n_pop[5:0], n_push[5:0]);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule